// File: doc/BRIEF.md
# Single-Vector Interrupt Controller

This block collects interrupt requests for a small processor core and turns them into one vectored entry. Every source event is caught in a flag bit that software can read and write. Flags are spread over a core register and two peripheral flag registers. Each flag has its own enable bit, and one global enable gates all of them. Flags latch even while they are masked, and they clear only when software writes them.

At each instruction boundary the core pulses `boundary_i`. If the global enable is set and at least one enabled flag is pending, the block raises `vec_take_o` in that cycle and presents the fixed vector address. From the next cycle on, the global enable is clear. A return pulse sets the global enable again, so a flag that is still set raises a new request. If software writes a 0 to the global enable in a boundary cycle, entry is held off. The flag stays set and is serviced once the enable is set again.

The external pin and the port lines are asynchronous. Each goes through a synchronizer and an edge or change detector before it sets a flag. The timer overflow and the peripheral events are single-cycle pulses that are already synchronous to the clock.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, every register address reads 0x00 and `vec_take_o` is low.
- R2: A source event sets its flag whatever the state of its enable bit and of the global enable.
- R3: If a hardware set event and a software write of 0 reach the same flag in one cycle, the flag ends up set.
- R4: `vec_take_o` is high only in a cycle where `boundary_i` is high, the global enable is set and some flag is set together with its enable bit.
- R5: After a cycle with `vec_take_o` high, the global enable (core bit 7) reads 0, and no further entry happens until it is set again. `vec_addr_o` is always 0x0004.
- R6: A `ret_i` pulse sets the global enable. A flag that is still set and enabled then causes another entry at the next boundary.
- R7: A core-register write with bit 7 = 0 in a boundary cycle stops entry in that cycle. The pending flag stays set and is taken at a later boundary once the global enable has been set again.
- R8: A rising edge on `ext_pin_i` sets core bit 2. The bit reads 1 from the third rising clock edge that samples the pin high, and a level that stays high sets the bit only once.
- R9: Any change on any line of `port_i` sets core bit 0. The bit follows the change with the same three-edge latency as R8, and one change sets the bit only once.
- R10: While `ext_alt_i` is high, an edge on the external pin sets no flag, and the external-pin flag does not count towards an entry.
- R11: Register map. Address 0 is the core register: bit 7 global enable, bit 6 reads 0, bits 5/4/3 enable external pin/timer/port change, bits 2/1/0 flag external pin/timer/port change. Address 1 holds peripheral flags A, address 2 peripheral flags B, address 3 enables A, address 4 enables B (bit i belongs to source line i). Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Instruction-cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| ret_i | input | 1 | Return-from-interrupt pulse |
| ext_pin_i | input | 1 | External interrupt pin (asynchronous) |
| ext_alt_i | input | 1 | External pin is assigned to an alternate output function |
| port_i | input | PORT_W | Port lines watched for change (asynchronous) |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| periph_a_i | input | PERIPH_W | Peripheral event pulses, group A |
| periph_b_i | input | PERIPH_W | Peripheral event pulses, group B |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| vec_take_o | output | 1 | Interrupt entry taken in this cycle |
| vec_addr_o | output | PC_W | Fixed vector address |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a boundary with a pending request meets a software write that clears the global enable. In the second, a hardware event meets a software write that clears its flag. The bench provokes both by driving the write strobe in the same cycle as the boundary strobe or the event pulse. A behavioural model predicts the result and is compared with the design on every clock: no entry and a flag that stays pending in the first case, a flag that stays set in the second.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef enum logic [2:0] {
      SEL_CORE   = 3'd0,
      SEL_FLAG_A = 3'd1,
      SEL_FLAG_B = 3'd2,
      SEL_EN_A   = 3'd3,
      SEL_EN_B   = 3'd4
   } reg_sel_e;

   localparam int REG_W       = 8;
   localparam int N_CORE_SRC  = 3;
   localparam int CORE_GIE    = 7;
   localparam int CORE_EN_LO  = 3;
   localparam int CORE_FL_EXT = 2;
   localparam int CORE_FL_TMR = 1;
   localparam int CORE_FL_CHG = 0;

   // Edge detector modes
   localparam int EDGE_RISE   = 0;
   localparam int EDGE_FALL   = 1;
   localparam int EDGE_ANY    = 2;

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
   parameter int W      = 1,
   parameter int STAGES = 2,
   parameter int MODE   = 0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] evt_o
);
   import irq_pkg::*;

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync_edge: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];
   logic [W-1:0] last_q;
   logic [W-1:0] cur;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
         last_q <= '0;
      end else begin
         stg_q[0] <= din_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
         last_q <= stg_q[STAGES-1];
      end
   end

   assign cur = stg_q[STAGES-1];

   if (MODE == EDGE_RISE) begin : g_rise
      assign evt_o = cur & ~last_q;
   end else if (MODE == EDGE_FALL) begin : g_fall
      assign evt_o = ~cur & last_q;
   end else begin : g_any
      assign evt_o = cur ^ last_q;
   end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] set_i,
   output logic [W-1:0] flags_o
);
   logic [W-1:0] flags_q;

   // Hardware set is ORed after the software write: set wins
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q <= '0;
      else         flags_q <= (wr_i ? wdata_i : flags_q) | set_i;
   end

   assign flags_o = flags_q;

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
   parameter int          PERIPH_W    = 8,
   parameter int          PORT_W      = 4,
   parameter int          SYNC_STAGES = 2,
   parameter bit          EXT_RISING  = 1'b1,
   parameter int          PC_W        = 13,
   parameter logic [31:0] VEC_ADDR    = 32'h0000_0004
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                boundary_i,
   input  logic                ret_i,
   input  logic                ext_pin_i,
   input  logic                ext_alt_i,
   input  logic [PORT_W-1:0]   port_i,
   input  logic                tmr_ovf_i,
   input  logic [PERIPH_W-1:0] periph_a_i,
   input  logic [PERIPH_W-1:0] periph_b_i,
   input  logic                reg_wr_i,
   input  logic [2:0]          reg_addr_i,
   input  logic [7:0]          reg_wdata_i,
   output logic [7:0]          reg_rdata_o,
   output logic                vec_take_o,
   output logic [PC_W-1:0]     vec_addr_o
);
   import irq_pkg::*;

   localparam int EXT_MODE = EXT_RISING ? EDGE_RISE : EDGE_FALL;

   if (PERIPH_W < 1 || PERIPH_W > REG_W) begin : g_bad_pw
      $error("irq_ctrl: PERIPH_W must lie in 1..8");
   end
   if (PORT_W < 1) begin : g_bad_port
      $error("irq_ctrl: PORT_W must be at least 1");
   end
   if (PC_W < 4 || PC_W > 32) begin : g_bad_pc
      $error("irq_ctrl: PC_W must lie in 4..32");
   end

   // ---------------- synchronized pin events ----------------
   logic              ext_evt;
   logic [PORT_W-1:0] chg_evt;

   irq_sync_edge #(.W(1), .STAGES(SYNC_STAGES), .MODE(EXT_MODE)) u_ext_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (ext_pin_i),
      .evt_o  (ext_evt)
   );

   irq_sync_edge #(.W(PORT_W), .STAGES(SYNC_STAGES), .MODE(EDGE_ANY)) u_port_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (port_i),
      .evt_o  (chg_evt)
   );

   // ---------------- write decode ----------------
   logic wr_core, wr_fa, wr_fb, wr_ea, wr_eb;
   always_comb begin
      wr_core = reg_wr_i && (reg_addr_i == SEL_CORE);
      wr_fa   = reg_wr_i && (reg_addr_i == SEL_FLAG_A);
      wr_fb   = reg_wr_i && (reg_addr_i == SEL_FLAG_B);
      wr_ea   = reg_wr_i && (reg_addr_i == SEL_EN_A);
      wr_eb   = reg_wr_i && (reg_addr_i == SEL_EN_B);
   end

   // ---------------- flag banks ----------------
   logic [N_CORE_SRC-1:0] core_set, core_flags;
   logic [PERIPH_W-1:0]   flag_a, flag_b;

   always_comb begin
      core_set              = '0;
      core_set[CORE_FL_EXT] = ext_evt & ~ext_alt_i;
      core_set[CORE_FL_TMR] = tmr_ovf_i;
      core_set[CORE_FL_CHG] = |chg_evt;
   end

   irq_flag_bank #(.W(N_CORE_SRC)) u_core_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_core),
      .wdata_i (reg_wdata_i[N_CORE_SRC-1:0]),
      .set_i   (core_set),
      .flags_o (core_flags)
   );

   irq_flag_bank #(.W(PERIPH_W)) u_flags_a (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_fa),
      .wdata_i (reg_wdata_i[PERIPH_W-1:0]),
      .set_i   (periph_a_i),
      .flags_o (flag_a)
   );

   irq_flag_bank #(.W(PERIPH_W)) u_flags_b (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_fb),
      .wdata_i (reg_wdata_i[PERIPH_W-1:0]),
      .set_i   (periph_b_i),
      .flags_o (flag_b)
   );

   // ---------------- enables ----------------
   logic [N_CORE_SRC-1:0] core_en_q;
   logic [PERIPH_W-1:0]   en_a_q, en_b_q;
   logic                  gie_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         core_en_q <= '0;
         en_a_q    <= '0;
         en_b_q    <= '0;
      end else begin
         if (wr_core) core_en_q <= reg_wdata_i[CORE_EN_LO +: N_CORE_SRC];
         if (wr_ea)   en_a_q    <= reg_wdata_i[PERIPH_W-1:0];
         if (wr_eb)   en_b_q    <= reg_wdata_i[PERIPH_W-1:0];
      end
   end

   // ---------------- request and entry ----------------
   logic [N_CORE_SRC-1:0] core_en_eff;
   logic                  pend, gie_sw_clear, take;

   always_comb begin
      core_en_eff              = core_en_q;
      core_en_eff[CORE_FL_EXT] = core_en_q[CORE_FL_EXT] & ~ext_alt_i;
      pend         = |(core_flags & core_en_eff) | |(flag_a & en_a_q) | |(flag_b & en_b_q);
      gie_sw_clear = wr_core && !reg_wdata_i[CORE_GIE];
      take         = boundary_i && gie_q && pend && !gie_sw_clear;
   end

   // Priority: entry clears, then return sets, then software write
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      gie_q <= 1'b0;
      else if (take)    gie_q <= 1'b0;
      else if (ret_i)   gie_q <= 1'b1;
      else if (wr_core) gie_q <= reg_wdata_i[CORE_GIE];
   end

   assign vec_take_o = take;
   assign vec_addr_o = VEC_ADDR[PC_W-1:0];

   // ---------------- read mux ----------------
   logic [7:0] fa_ext, fb_ext, ea_ext, eb_ext;
   always_comb begin
      fa_ext = '0; fa_ext[PERIPH_W-1:0] = flag_a;
      fb_ext = '0; fb_ext[PERIPH_W-1:0] = flag_b;
      ea_ext = '0; ea_ext[PERIPH_W-1:0] = en_a_q;
      eb_ext = '0; eb_ext[PERIPH_W-1:0] = en_b_q;
      unique case (reg_addr_i)
         SEL_CORE:   reg_rdata_o = {gie_q, 1'b0, core_en_q, core_flags};
         SEL_FLAG_A: reg_rdata_o = fa_ext;
         SEL_FLAG_B: reg_rdata_o = fb_ext;
         SEL_EN_A:   reg_rdata_o = ea_ext;
         SEL_EN_B:   reg_rdata_o = eb_ext;
         default:    reg_rdata_o = 8'h00;
      endcase
   end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int PERIPH_W = 8
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                boundary_i,
   input logic                ret_i,
   input logic                ext_alt_i,
   input logic                tmr_ovf_i,
   input logic                reg_wr_i,
   input logic [2:0]          reg_addr_i,
   input logic                wdata_gie_i,
   input logic                vec_take_i,
   input logic                gie_i,
   input logic [2:0]          core_fl_i,
   input logic [PERIPH_W-1:0] fa_i
);

   // R4: entry only at a boundary with the global enable set
   assert_take_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_take_i |-> (boundary_i && gie_i));

   // R5: entry clears the global enable
   assert_gie_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_take_i |=> !gie_i);

   // R6: return sets the global enable
   assert_ret_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_i && !vec_take_i) |=> gie_i);

   // R7: software clear of the enable in a boundary cycle holds off entry
   assert_sw_clear_defers_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (boundary_i && reg_wr_i && reg_addr_i == 3'd0 && !wdata_gie_i) |-> !vec_take_i);

   // R3: timer event sets its flag even against a clearing write
   assert_set_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmr_ovf_i |=> core_fl_i[1]);

   // R2: peripheral A flags fall only through a write
   assert_flags_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(reg_wr_i && reg_addr_i == 3'd1) |=> ((fa_i & $past(fa_i)) == $past(fa_i)));

   // R10: pin in alternate use cannot raise its flag
   assert_alt_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_alt_i && !core_fl_i[2] && !(reg_wr_i && reg_addr_i == 3'd0)) |=> !core_fl_i[2]);

endmodule

bind irq_ctrl irq_ctrl_chk #(.PERIPH_W(PERIPH_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .boundary_i  (boundary_i),
   .ret_i       (ret_i),
   .ext_alt_i   (ext_alt_i),
   .tmr_ovf_i   (tmr_ovf_i),
   .reg_wr_i    (reg_wr_i),
   .reg_addr_i  (reg_addr_i),
   .wdata_gie_i (reg_wdata_i[7]),
   .vec_take_i  (vec_take_o),
   .gie_i       (gie_q),
   .core_fl_i   (core_flags),
   .fa_i        (flag_a)
);

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       boundary = 1'b0, ret = 1'b0, ext_pin = 1'b0, ext_alt = 1'b0, tmr = 1'b0;
   logic [3:0] port = '0;
   logic [7:0] pa = '0, pb = '0;
   logic       wr = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       take;
   logic [12:0] vaddr;

   int    nvec = 0;
   int    nerr = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   irq_ctrl uut (
      .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary), .ret_i(ret),
      .ext_pin_i(ext_pin), .ext_alt_i(ext_alt), .port_i(port), .tmr_ovf_i(tmr),
      .periph_a_i(pa), .periph_b_i(pb), .reg_wr_i(wr), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .vec_take_o(take), .vec_addr_o(vaddr)
   );

   // ---------------- behavioural reference ----------------
   logic       m_gie = 0;
   logic [2:0] m_cf = 0, m_cen = 0;
   logic [7:0] m_fa = 0, m_fb = 0, m_ea = 0, m_eb = 0;
   logic       m_e1 = 0, m_e2 = 0, m_ep = 0;
   logic [3:0] m_p1 = 0, m_p2 = 0, m_pp = 0;

   function automatic logic exp_take();
      logic [2:0] cen;
      logic       any;
      cen = m_cen;
      if (ext_alt) cen[2] = 1'b0;
      any = ((m_cf & cen) != 0) || ((m_fa & m_ea) != 0) || ((m_fb & m_eb) != 0);
      return boundary && m_gie && any && !(wr && addr == 3'd0 && !wdata[7]);
   endfunction

   function automatic logic [7:0] exp_rd();
      case (addr)
         3'd0: return {m_gie, 1'b0, m_cen, m_cf};
         3'd1: return m_fa;
         3'd2: return m_fb;
         3'd3: return m_ea;
         3'd4: return m_eb;
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_gie = 0; m_cf = 0; m_cen = 0; m_fa = 0; m_fb = 0; m_ea = 0; m_eb = 0;
         m_e1 = 0; m_e2 = 0; m_ep = 0; m_p1 = 0; m_p2 = 0; m_pp = 0;
      end else begin
         logic tk, e_ev, p_ev, wcore;
         tk    = exp_take();
         e_ev  = m_e2 && !m_ep && !ext_alt;
         p_ev  = (m_p2 != m_pp);
         m_ep = m_e2; m_e2 = m_e1; m_e1 = ext_pin;
         m_pp = m_p2; m_p2 = m_p1; m_p1 = port;
         wcore = wr && addr == 3'd0;
         if (wcore) begin m_cf = wdata[2:0]; m_cen = wdata[5:3]; end
         m_cf = m_cf | {e_ev, tmr, p_ev};
         if (wr && addr == 3'd1) m_fa = wdata;
         m_fa = m_fa | pa;
         if (wr && addr == 3'd2) m_fb = wdata;
         m_fb = m_fb | pb;
         if (wr && addr == 3'd3) m_ea = wdata;
         if (wr && addr == 3'd4) m_eb = wdata;
         if (tk)         m_gie = 0;
         else if (ret)   m_gie = 1;
         else if (wcore) m_gie = wdata[7];
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (rst_n) begin
         nvec++;
         if (take !== exp_take() || rdata !== exp_rd() || vaddr !== 13'h0004) begin
            nerr++;
            $display("FAIL %s cycle compare: take=%0b rdata=%02h vaddr=%0h, expected take=%0b rdata=%02h vaddr=4",
                     cur_req, take, rdata, vaddr, exp_take(), exp_rd());
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); #1;
      boundary = 0; ret = 0; tmr = 0; pa = 0; pb = 0; wr = 0;
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      cyc(); wr = 1; addr = a; wdata = d;
      cyc();
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      cur_req = "R1";
      for (int a = 0; a < 8; a++) begin
         addr = a[2:0];
         @(negedge clk);
         check("R1 reset read", {8'h0, rdata}, 16'h0000);
      end
      check("R1 no entry", {15'h0, take}, 16'h0);

      cur_req = "R2";
      cyc(); tmr = 1; pa = 8'h81;
      cyc(); addr = 3'd0;
      @(negedge clk); check("R2 timer flag masked", {8'h0, rdata}, 16'h0002);
      addr = 3'd1;
      @(negedge clk); check("R2 periph A flags masked", {8'h0, rdata}, 16'h0081);

      cur_req = "R3";
      cyc(); wr = 1; addr = 3'd1; wdata = 8'h00; pa = 8'h10;
      cyc();
      @(negedge clk); check("R3 set beats clear", {8'h0, rdata}, 16'h0010);
      wr_reg(3'd0, 8'h00);

      cur_req = "R4";
      wr_reg(3'd3, 8'h10);
      wr_reg(3'd0, 8'h80);
      addr = 3'd0;
      @(negedge clk); check("R4 no boundary no entry", {15'h0, take}, 16'h0);
      check("R11 core layout", {8'h0, rdata}, 16'h0080);
      cyc(); boundary = 1;
      @(negedge clk); check("R4 entry at boundary", {15'h0, take}, 16'h1);
      check("R5 vector address", {3'h0, vaddr}, 16'h0004);
      cur_req = "R5";
      cyc();
      @(negedge clk); check("R5 enable cleared", {8'h0, rdata}, 16'h0000);
      cyc(); boundary = 1;
      @(negedge clk); check("R5 no reentry", {15'h0, take}, 16'h0);

      cur_req = "R6";
      cyc(); ret = 1;
      cyc();
      @(negedge clk); check("R6 return sets enable", {8'h0, rdata}, 16'h0080);
      cyc(); boundary = 1;
      @(negedge clk); check("R6 still-set flag reenters", {15'h0, take}, 16'h1);
      cyc();
      wr_reg(3'd1, 8'h00);
      cyc(); ret = 1;
      cyc(); boundary = 1;
      @(negedge clk); check("R4 nothing pending", {15'h0, take}, 16'h0);

      cur_req = "R7";
      cyc(); pa = 8'h10;
      cyc(); boundary = 1; wr = 1; addr = 3'd0; wdata = 8'h00;
      @(negedge clk); check("R7 clear write defers entry", {15'h0, take}, 16'h0);
      cyc(); addr = 3'd1;
      @(negedge clk); check("R7 flag still pending", {8'h0, rdata}, 16'h0010);
      wr_reg(3'd0, 8'h80);
      cyc(); boundary = 1;
      @(negedge clk); check("R7 deferred entry taken", {15'h0, take}, 16'h1);
      cyc();
      wr_reg(3'd1, 8'h00);
      wr_reg(3'd3, 8'h00);

      cur_req = "R8";
      wr_reg(3'd0, 8'h20);
      addr = 3'd0;
      cyc(); ext_pin = 1;
      cyc();
      @(negedge clk); check("R8 first edge", {8'h0, rdata}, 16'h0020);
      cyc();
      @(negedge clk); check("R8 second edge", {8'h0, rdata}, 16'h0020);
      cyc();
      @(negedge clk); check("R8 third edge sets flag", {8'h0, rdata}, 16'h0024);
      wr_reg(3'd0, 8'h20);
      cyc(); cyc();
      @(negedge clk); check("R8 held level sets once", {8'h0, rdata}, 16'h0020);

      cur_req = "R9";
      cyc(); ext_pin = 0; port = 4'b0100;
      cyc(); cyc(); cyc();
      @(negedge clk); check("R9 port change flag", {8'h0, rdata}, 16'h0021);
      wr_reg(3'd0, 8'h20);
      cyc(); cyc(); cyc();
      @(negedge clk); check("R9 one change sets once", {8'h0, rdata}, 16'h0020);

      cur_req = "R10";
      cyc(); ext_alt = 1; ext_pin = 1;
      repeat (4) cyc();
      @(negedge clk); check("R10 alt blocks flag", {8'h0, rdata}, 16'h0020);
      cyc(); ext_pin = 0; ext_alt = 0;
      repeat (3) cyc();
      ext_pin = 1;
      repeat (3) cyc();
      @(negedge clk); check("R8 edge after alt off", {8'h0, rdata}, 16'h0024);
      wr_reg(3'd0, 8'hA4);
      cyc(); ext_alt = 1; boundary = 1;
      @(negedge clk); check("R10 alt masks request", {15'h0, take}, 16'h0);
      cyc(); ext_alt = 0; boundary = 1;
      @(negedge clk); check("R10 request after alt off", {15'h0, take}, 16'h1);
      cyc();
      @(negedge clk);

      finish_run();
   end

endmodule